// File: doc/BRIEF.md
# Host-Programmed Two-Wire Register Access Engine

This block lets a host processor read and write single bytes in the registers of an image sensor over a two-wire serial bus of the SCCB/I2C kind. The host sees a small byte-wide register window. It arms the engine with an enable key and loads a device address. It then loads an index, plus a data byte for writes, and starts a transfer by writing an opcode. The engine generates the serial waveform, checks each acknowledge and posts a completion code that the host polls.

A write transfer sends a start condition, the address byte with the direction bit clear, the index, the data byte and a stop condition. A read transfer first sends a start condition, the address byte for writing, the index and a stop condition. It then sends a new start condition and the address byte with the direction bit set, takes in one byte, answers it with a not-acknowledge, and ends with a stop condition. The serial clock comes from the system clock through a parameterised divider: each bit is four quarter-phases of `CLK_DIV` clocks each.

Top module: `sccb_engine`

## Requirements
- R1: After reset, status, read-value and enable registers read 0x00. SCL is high and SDA is released (`sdaDriveLow` low).
- R2: These registers read back what the host last wrote to them, at these offsets from `BASE` 0x200: enable +2, slave address +3, write index +4, write value +5, read index +8. The operation register at +0 and unmapped offsets read 0x00. Status is at +1 and read value is at +9.
- R3: With the enable register holding 0x1e, writing 0x05 to the operation register produces start, address byte {slaveAddr[7:1],0}, write index, write value, stop on the bus. The status register then reads 0x04.
- R4: With the engine enabled, writing 0x70 to the operation register produces start, {slaveAddr[7:1],0}, read index, stop, start, {slaveAddr[7:1],1}, eight data bits answered by a not-acknowledge (SDA high), stop. The status register then reads 0x01 and the read-value register holds the received byte, most significant bit first.
- R5: When an opcode is accepted, status becomes 0x00 on the next clock edge. It stays 0x00 until the transfer ends.
- R6: If any address, index or data byte sent by the engine is not acknowledged (SDA high in the ninth bit), the engine skips the remaining bytes and sends a stop. Status then reads 0x80, and the read-value register keeps its previous contents.
- R7: An opcode write is ignored while the enable register holds any value other than 0x1e. Any opcode byte other than 0x05 or 0x70 is also ignored. No bus activity follows and status keeps its value.
- R8: An opcode written while a transfer is in progress is ignored. The running transfer completes unchanged.
- R9: While a data or acknowledge bit is on the bus, SDA changes only while SCL is low. With no transfer in progress, SCL is high and SDA is released.
- R10: SCL has a period of 4×`CLK_DIV` system clocks. With `CLK_DIV`=4, a complete read finishes between 630 and 650 clocks after the opcode write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| hostAddr | input | 12 | Host register address |
| hostWrEn | input | 1 | Host write strobe, one clock per write |
| hostWrData | input | 8 | Host write data |
| hostRdData | output | 8 | Host read data, combinational from hostAddr |
| sclOut | output | 1 | Serial clock |
| sdaDriveLow | output | 1 | Pulls the data line low when high, releases it when low |
| sdaIn | input | 1 | Resolved level of the data line |

## Verification
The hardest situations to reach from the ports are an acknowledge failure part-way through a frame and an opcode that arrives during a transfer. A behavioural sensor model on the bus answers only its own device address. Programming a different slave address therefore makes the address byte go unacknowledged, for both a write and a read. A second opcode is written ten clocks into a running write. A scoreboard compares every start, stop and byte with its acknowledge bit against the frames the bench expects, so an accepted stray opcode shows up as an extra frame.

// File: rtl/sccb_pkg.sv
package sccb_pkg;
  localparam int BYTE_W = 8;

  localparam logic [BYTE_W-1:0] OPC_WRITE = 8'h05;
  localparam logic [BYTE_W-1:0] OPC_READ  = 8'h70;
  localparam logic [BYTE_W-1:0] ST_WR_OK  = 8'h04;
  localparam logic [BYTE_W-1:0] ST_RD_OK  = 8'h01;
  localparam logic [BYTE_W-1:0] ST_FAIL   = 8'h80;
  localparam logic [BYTE_W-1:0] EN_KEY    = 8'h1e;

  typedef enum logic [1:0] {REQ_NONE, REQ_WR, REQ_RD} req_e;
  typedef enum logic [2:0] {SRC_ADDR_W, SRC_ADDR_R, SRC_WIDX, SRC_WVAL, SRC_RIDX} src_e;
  typedef enum logic [1:0] {SEG_START, SEG_TX, SEG_RX, SEG_STOP} seg_e;

  typedef struct packed {
    logic              accept;
    logic              load;
    src_e              loadSrc;
    logic              shiftTx;
    logic              shiftRx;
    logic              rxBit;
    logic              finish;
    logic [BYTE_W-1:0] code;
    logic              storeRx;
  } strobe_t;
endpackage

// File: rtl/sccb_regs.sv
module sccb_regs
  import sccb_pkg::*;
#(
  parameter int AW = 12,
  parameter logic [AW-1:0] BASE = 12'h200
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [AW-1:0]     hostAddr,
  input  logic              hostWrEn,
  input  logic [BYTE_W-1:0] hostWrData,
  output logic [BYTE_W-1:0] hostRdData,
  input  strobe_t           strb,
  output req_e              opReq,
  output logic              shiftMsb,
  output logic [BYTE_W-1:0] statusOut
);
  localparam logic [AW-1:0] A_OP  = BASE;
  localparam logic [AW-1:0] A_ST  = BASE + AW'(1);
  localparam logic [AW-1:0] A_EN  = BASE + AW'(2);
  localparam logic [AW-1:0] A_SA  = BASE + AW'(3);
  localparam logic [AW-1:0] A_WI  = BASE + AW'(4);
  localparam logic [AW-1:0] A_WV  = BASE + AW'(5);
  localparam logic [AW-1:0] A_RI  = BASE + AW'(8);
  localparam logic [AW-1:0] A_RV  = BASE + AW'(9);

  logic [BYTE_W-1:0] enReg, slaveReg, wIdx, wVal, rIdx, rVal, status, shiftReg;

  // opcode decode; only a recognised byte with the key present counts
  always_comb begin
    opReq = REQ_NONE;
    if (hostWrEn && hostAddr == A_OP && enReg == EN_KEY) begin
      if (hostWrData == OPC_WRITE)     opReq = REQ_WR;
      else if (hostWrData == OPC_READ) opReq = REQ_RD;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      enReg    <= '0;
      slaveReg <= '0;
      wIdx     <= '0;
      wVal     <= '0;
      rIdx     <= '0;
    end else if (hostWrEn) begin
      case (hostAddr)
        A_EN:    enReg    <= hostWrData;
        A_SA:    slaveReg <= hostWrData;
        A_WI:    wIdx     <= hostWrData;
        A_WV:    wVal     <= hostWrData;
        A_RI:    rIdx     <= hostWrData;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      status <= '0;
      rVal   <= '0;
    end else begin
      if (strb.accept)      status <= '0;
      else if (strb.finish) status <= strb.code;
      if (strb.storeRx)     rVal   <= shiftReg;
    end
  end

  // byte shifter shared by transmit and receive
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftReg <= '1;
    end else if (strb.load) begin
      case (strb.loadSrc)
        SRC_ADDR_W: shiftReg <= {slaveReg[BYTE_W-1:1], 1'b0};
        SRC_ADDR_R: shiftReg <= {slaveReg[BYTE_W-1:1], 1'b1};
        SRC_WIDX:   shiftReg <= wIdx;
        SRC_WVAL:   shiftReg <= wVal;
        default:    shiftReg <= rIdx;
      endcase
    end else if (strb.shiftTx) begin
      shiftReg <= {shiftReg[BYTE_W-2:0], 1'b1};
    end else if (strb.shiftRx) begin
      shiftReg <= {shiftReg[BYTE_W-2:0], strb.rxBit};
    end
  end

  assign shiftMsb  = shiftReg[BYTE_W-1];
  assign statusOut = status;

  always_comb begin
    case (hostAddr)
      A_ST:    hostRdData = status;
      A_EN:    hostRdData = enReg;
      A_SA:    hostRdData = slaveReg;
      A_WI:    hostRdData = wIdx;
      A_WV:    hostRdData = wVal;
      A_RI:    hostRdData = rIdx;
      A_RV:    hostRdData = rVal;
      default: hostRdData = '0;
    endcase
  end

  // R4
  rx_store_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.storeRx |-> (strb.finish && strb.code == ST_RD_OK));

  // R5
  accept_finish_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(strb.accept && strb.finish));
endmodule

// File: rtl/sccb_ctrl.sv
module sccb_ctrl
  import sccb_pkg::*;
#(
  parameter int CLK_DIV = 4
) (
  input  logic    clk,
  input  logic    rstN,
  input  req_e    opReq,
  input  logic    sdaIn,
  input  logic    shiftMsb,
  output strobe_t strb,
  output logic    sclOut,
  output logic    sdaDriveLow,
  output logic    busy
);
  localparam int DIV_W  = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1;
  localparam int BITS   = BYTE_W + 1;
  localparam int SEG_W  = 4;
  localparam int BCNT_W = $clog2(BITS + 1);

  logic              isRead, nack;
  logic [SEG_W-1:0]  segIdx, nextSeg, endIdx, stopIdx;
  logic [1:0]        phase;
  logic [BCNT_W-1:0] bitCnt;
  logic [DIV_W-1:0]  divCnt;
  logic              tick, segEnd, nextIsEnd, lastBit;
  seg_e              curKind;

  function automatic seg_e kindOf(input logic rd, input logic [SEG_W-1:0] idx);
    if (!rd) begin
      case (idx)
        4'd0:    return SEG_START;
        4'd4:    return SEG_STOP;
        default: return SEG_TX;
      endcase
    end else begin
      case (idx)
        4'd0, 4'd4: return SEG_START;
        4'd3, 4'd7: return SEG_STOP;
        4'd6:       return SEG_RX;
        default:    return SEG_TX;
      endcase
    end
  endfunction

  function automatic src_e srcOf(input logic rd, input logic [SEG_W-1:0] idx);
    case (idx)
      4'd2:    return rd ? SRC_RIDX : SRC_WIDX;
      4'd3:    return SRC_WVAL;
      4'd5:    return SRC_ADDR_R;
      default: return SRC_ADDR_W;
    endcase
  endfunction

  assign curKind   = kindOf(isRead, segIdx);
  assign endIdx    = isRead ? 4'd8 : 4'd5;
  assign stopIdx   = isRead ? 4'd7 : 4'd4;
  assign tick      = busy && divCnt == '0;
  assign lastBit   = bitCnt == BCNT_W'(BITS - 1);
  assign segEnd    = phase == 2'd3 &&
                     ((curKind == SEG_START || curKind == SEG_STOP) || lastBit);
  assign nextSeg   = (curKind == SEG_TX && nack) ? stopIdx : segIdx + 4'd1;
  assign nextIsEnd = nextSeg == endIdx;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busy   <= 1'b0;
      isRead <= 1'b0;
      nack   <= 1'b0;
      segIdx <= '0;
      phase  <= '0;
      bitCnt <= '0;
      divCnt <= '0;
    end else if (!busy) begin
      if (opReq != REQ_NONE) begin
        busy   <= 1'b1;
        isRead <= opReq == REQ_RD;
        nack   <= 1'b0;
        segIdx <= '0;
        phase  <= '0;
        bitCnt <= '0;
        divCnt <= DIV_W'(CLK_DIV - 1);
      end
    end else if (!tick) begin
      divCnt <= divCnt - 1'b1;
    end else begin
      divCnt <= DIV_W'(CLK_DIV - 1);
      phase  <= phase + 2'd1;
      if (phase == 2'd2 && curKind == SEG_TX && lastBit && sdaIn) nack <= 1'b1;
      if (phase == 2'd3) begin
        if (segEnd) begin
          segIdx <= nextSeg;
          bitCnt <= '0;
          if (nextIsEnd) busy <= 1'b0;
        end else begin
          bitCnt <= bitCnt + 1'b1;
        end
      end
    end
  end

  always_comb begin
    strb         = '0;
    strb.accept  = !busy && opReq != REQ_NONE;
    strb.load    = tick && segEnd && !nextIsEnd && kindOf(isRead, nextSeg) == SEG_TX;
    strb.loadSrc = srcOf(isRead, nextSeg);
    strb.shiftTx = tick && phase == 2'd3 && curKind == SEG_TX && !lastBit;
    strb.shiftRx = tick && phase == 2'd2 && curKind == SEG_RX && !lastBit;
    strb.rxBit   = sdaIn;
    strb.finish  = tick && segEnd && nextIsEnd;
    strb.code    = nack ? ST_FAIL : (isRead ? ST_RD_OK : ST_WR_OK);
    strb.storeRx = strb.finish && isRead && !nack;
  end

  // bus waveform per segment and quarter-phase
  always_comb begin
    sclOut      = 1'b1;
    sdaDriveLow = 1'b0;
    if (busy) begin
      case (curKind)
        SEG_START: begin
          sclOut      = phase < 2'd2;
          sdaDriveLow = phase != 2'd0;
        end
        SEG_STOP: begin
          sclOut      = phase != 2'd0;
          sdaDriveLow = phase < 2'd2;
        end
        SEG_TX: begin
          sclOut      = phase == 2'd1 || phase == 2'd2;
          sdaDriveLow = !lastBit && !shiftMsb;
        end
        default: begin
          sclOut      = phase == 2'd1 || phase == 2'd2;
          sdaDriveLow = 1'b0;
        end
      endcase
    end
  end

  // R9
  sda_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busy && $past(busy) && (curKind == SEG_TX || curKind == SEG_RX) && sclOut && $past(sclOut))
      |-> sdaDriveLow == $past(sdaDriveLow));

  // R9
  bus_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> (sclOut && !sdaDriveLow));

  // R8
  mode_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busy && $past(busy)) |-> ($stable(isRead) && !strb.accept));

  // R3
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.load, strb.shiftTx, strb.shiftRx}));

  // R4
  rx_mode_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.shiftRx |-> isRead);
endmodule

// File: rtl/sccb_engine.sv
module sccb_engine
  import sccb_pkg::*;
#(
  parameter int AW = 12,
  parameter logic [AW-1:0] BASE = 12'h200,
  parameter int CLK_DIV = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [AW-1:0]     hostAddr,
  input  logic              hostWrEn,
  input  logic [BYTE_W-1:0] hostWrData,
  output logic [BYTE_W-1:0] hostRdData,
  output logic              sclOut,
  output logic              sdaDriveLow,
  input  logic              sdaIn
);
  strobe_t           strb;
  req_e              opReq;
  logic              shiftMsb, busy;
  logic [BYTE_W-1:0] statusOut;

  sccb_regs #(.AW(AW), .BASE(BASE)) regsI (
    .clk(clk), .rstN(rstN), .hostAddr(hostAddr), .hostWrEn(hostWrEn),
    .hostWrData(hostWrData), .hostRdData(hostRdData), .strb(strb),
    .opReq(opReq), .shiftMsb(shiftMsb), .statusOut(statusOut)
  );

  sccb_ctrl #(.CLK_DIV(CLK_DIV)) ctrlI (
    .clk(clk), .rstN(rstN), .opReq(opReq), .sdaIn(sdaIn), .shiftMsb(shiftMsb),
    .strb(strb), .sclOut(sclOut), .sdaDriveLow(sdaDriveLow), .busy(busy)
  );

  // R5
  busy_status_chk: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> statusOut == '0);

  // R5
  done_code_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($past(busy) && !busy) |-> statusOut != '0);
endmodule

// File: tb/sccb_engine_test.sv
`timescale 1ns/100ps
module sccb_engine_test;
  localparam int DIV = 4;
  localparam logic [6:0] SLV_DEV = 7'h30;
  localparam logic [11:0] B = 12'h200;

  logic clk = 0, rstN = 0, hostWrEn = 0;
  logic [11:0] hostAddr = 0;
  logic [7:0] hostWrData = 0, hostRdData;
  logic scl, sdaDriveLow, slvLow = 0;
  wire sdaBus = !(sdaDriveLow || slvLow);

  int checks = 0, errors = 0;
  bit finished = 0;
  string curReq = "R3";

  always #2.5 clk = ~clk;

  sccb_engine #(.CLK_DIV(DIV)) uut (
    .clk(clk), .rstN(rstN), .hostAddr(hostAddr), .hostWrEn(hostWrEn),
    .hostWrData(hostWrData), .hostRdData(hostRdData), .sclOut(scl),
    .sdaDriveLow(sdaDriveLow), .sdaIn(sdaBus)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // ---------------- scoreboard: token = {kind[1:0], ack, data} ----------------
  localparam logic [1:0] K_BYTE = 2'd0, K_START = 2'd1, K_STOP = 2'd2;
  logic [10:0] expQ[$];

  task automatic expect_tok(input logic [1:0] k, input logic ack, input logic [7:0] d);
    expQ.push_back({k, ack, d});
  endtask

  function automatic void observe(input logic [10:0] tok);
    logic [10:0] e;
    checks++;
    if (expQ.size() == 0) begin
      errors++;
      $display("FAIL %s unexpected bus token actual=0x%0h expected=none", curReq, tok);
    end else begin
      e = expQ.pop_front();
      if (e != tok) begin
        errors++;
        $display("FAIL %s bus token actual=0x%0h expected=0x%0h", curReq, tok, e);
      end
    end
  endfunction

  int mBits = 0;
  logic [7:0] mSh = 0;
  bit mActive = 0;
  always @(negedge sdaBus) if (scl === 1'b1) begin
    observe({K_START, 1'b0, 8'h00}); mBits = 0; mActive = 1;
  end
  always @(posedge sdaBus) if (scl === 1'b1 && mActive) begin
    observe({K_STOP, 1'b0, 8'h00}); mActive = 0;
  end
  always @(posedge scl) if (mActive) begin
    if (mBits < 8) begin mSh = {mSh[6:0], sdaBus}; mBits++; end
    else begin observe({K_BYTE, sdaBus, mSh}); mBits = 0; end
  end

  // ---------------- behavioural sensor slave ----------------
  logic [7:0] sRegs [256];
  int sBits = 0, sByte = -1;
  logic [7:0] sSh = 0, sTx = 0, sPtr = 0;
  bit sMatch = 0, sRdPend = 0, sRdMode = 0;
  initial for (int i = 0; i < 256; i++) sRegs[i] = 8'(i) ^ 8'h5a;

  always @(negedge sdaBus) if (scl === 1'b1) begin
    sBits = 0; sByte = 0; sMatch = 0; sRdPend = 0; sRdMode = 0;
  end
  always @(posedge sdaBus) if (scl === 1'b1) sByte = -1;
  always @(posedge scl) if (sByte >= 0) begin
    if (!sRdMode && sBits < 8) sSh = {sSh[6:0], sdaBus};
    sBits++;
  end
  always @(negedge scl) if (sByte >= 0) begin
    if (sBits == 8) begin
      if (sRdMode) slvLow = 0;
      else begin
        if (sByte == 0) begin sMatch = (sSh[7:1] == SLV_DEV); sRdPend = sSh[0]; end
        else if (sMatch && sByte == 1) sPtr = sSh;
        else if (sMatch) begin sRegs[sPtr] = sSh; sPtr++; end
        slvLow = sMatch;
      end
    end else if (sBits == 9) begin
      sBits = 0; sByte++; slvLow = 0;
      if (sMatch && sRdPend && !sRdMode) begin
        sRdMode = 1; sTx = sRegs[sPtr]; slvLow = !sTx[7];
      end
    end else if (sRdMode && sBits >= 1 && sBits <= 7) begin
      slvLow = !sTx[7 - sBits];
    end
  end

  // ---------------- host driver ----------------
  task automatic hostWr(input logic [11:0] a, input logic [7:0] d);
    @(negedge clk); hostAddr = a; hostWrData = d; hostWrEn = 1;
    @(negedge clk); hostWrEn = 0;
  endtask

  task automatic hostRd(input logic [11:0] a, output logic [7:0] d);
    @(negedge clk); hostAddr = a; #1 d = hostRdData;
  endtask

  task automatic waitDone(output logic [7:0] st);
    st = 0;
    for (int p = 0; p < 50 && st == 0; p++) begin
      repeat (20) @(negedge clk);
      hostRd(B + 12'd1, st);
    end
  endtask

  task automatic expWrite(input logic [7:0] a, input logic [7:0] i, input logic [7:0] v);
    expect_tok(K_START, 0, 0); expect_tok(K_BYTE, 0, a);
    expect_tok(K_BYTE, 0, i);  expect_tok(K_BYTE, 0, v); expect_tok(K_STOP, 0, 0);
  endtask

  task automatic expRead(input logic [7:0] a, input logic [7:0] i, input logic [7:0] v);
    expect_tok(K_START, 0, 0); expect_tok(K_BYTE, 0, a);     expect_tok(K_BYTE, 0, i);
    expect_tok(K_STOP, 0, 0);  expect_tok(K_START, 0, 0);
    expect_tok(K_BYTE, 0, a | 8'h01); expect_tok(K_BYTE, 1, v); expect_tok(K_STOP, 0, 0);
  endtask

  task automatic expNack(input logic [7:0] a);
    expect_tok(K_START, 0, 0); expect_tok(K_BYTE, 1, a); expect_tok(K_STOP, 0, 0);
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual=timeout expected=completion");
    summary();
  end

  initial begin
    logic [7:0] v;
    realtime t1, t2;
    int cyc;
    repeat (4) @(negedge clk);
    rstN = 1;

    // R1 reset state
    hostRd(B + 12'd1, v); chk("R1 status", v, 8'h00);
    hostRd(B + 12'd9, v); chk("R1 rxval", v, 8'h00);
    hostRd(B + 12'd2, v); chk("R1 enable", v, 8'h00);
    chk("R1 scl", scl, 1);
    chk("R1 sda", sdaDriveLow, 0);

    // R2 register readback
    hostWr(B + 12'd2, 8'h1e); hostWr(B + 12'd3, 8'h60);
    hostWr(B + 12'd4, 8'h12); hostWr(B + 12'd5, 8'hA7); hostWr(B + 12'd8, 8'h12);
    hostRd(B + 12'd2, v); chk("R2 enable", v, 8'h1e);
    hostRd(B + 12'd3, v); chk("R2 slave", v, 8'h60);
    hostRd(B + 12'd4, v); chk("R2 widx", v, 8'h12);
    hostRd(B + 12'd5, v); chk("R2 wval", v, 8'hA7);
    hostRd(B + 12'd8, v); chk("R2 ridx", v, 8'h12);
    hostRd(B + 12'd0, v); chk("R2 op reads zero", v, 8'h00);

    // R3 write, R10 SCL period
    curReq = "R3";
    expWrite(8'h60, 8'h12, 8'hA7);
    hostWr(B, 8'h05);
    hostRd(B + 12'd1, v); chk("R5 status cleared on accept", v, 8'h00);
    @(posedge scl); t1 = $realtime;
    @(posedge scl); t2 = $realtime;
    chk("R10 scl period ns", int'(t2 - t1), 4 * DIV * 5);
    waitDone(v); chk("R3 write status", v, 8'h04);
    chk("R3 slave got data", sRegs[8'h12], 8'hA7);

    // R8 opcode while busy is ignored
    curReq = "R8";
    hostWr(B + 12'd4, 8'h20); hostWr(B + 12'd5, 8'h3C);
    expWrite(8'h60, 8'h20, 8'h3C);
    hostWr(B, 8'h05);
    repeat (10) @(negedge clk);
    hostWr(B, 8'h70);
    hostRd(B + 12'd1, v); chk("R5 status zero while busy", v, 8'h00);
    waitDone(v); chk("R8 status stays write code", v, 8'h04);
    repeat (200) @(negedge clk);
    chk("R8 no extra frame", expQ.size(), 0);

    // R4 read, R10 duration
    curReq = "R4";
    expRead(8'h60, 8'h12, 8'hA7);
    hostWr(B, 8'h70);
    cyc = 0; v = 0;
    while (v == 0 && cyc < 2000) begin hostRd(B + 12'd1, v); cyc++; end
    chk("R4 read status", v, 8'h01);
    checks++;
    if (cyc < 630 || cyc > 650) begin
      errors++; $display("FAIL R10 read duration actual=%0d expected=630..650", cyc);
    end
    hostRd(B + 12'd9, v); chk("R4 read value", v, 8'hA7);

    hostWr(B + 12'd8, 8'h20);
    expRead(8'h60, 8'h20, 8'h3C);
    hostWr(B, 8'h70);
    waitDone(v); chk("R4 read status 2", v, 8'h01);
    hostRd(B + 12'd9, v); chk("R4 read value 2", v, 8'h3C);

    hostWr(B + 12'd8, 8'h40);
    expRead(8'h60, 8'h40, 8'h1a);
    hostWr(B, 8'h70);
    waitDone(v); chk("R4 read status 3", v, 8'h01);
    hostRd(B + 12'd9, v); chk("R4 read value 3", v, 8'h1a);

    // R6 missing acknowledge
    curReq = "R6";
    hostWr(B + 12'd3, 8'h62);
    expNack(8'h62);
    hostWr(B, 8'h05);
    waitDone(v); chk("R6 write fail status", v, 8'h80);
    expNack(8'h62);
    hostWr(B, 8'h70);
    waitDone(v); chk("R6 read fail status", v, 8'h80);
    hostRd(B + 12'd9, v); chk("R6 rxval kept", v, 8'h1a);

    // R7 disabled engine and unknown opcode
    curReq = "R7";
    hostWr(B + 12'd3, 8'h60);
    hostWr(B + 12'd2, 8'h00);
    hostWr(B, 8'h05);
    repeat (100) @(negedge clk);
    hostRd(B + 12'd1, v); chk("R7 disabled status kept", v, 8'h80);
    chk("R7 scl idle", scl, 1);
    hostWr(B + 12'd2, 8'h1e);
    hostWr(B, 8'h33);
    repeat (100) @(negedge clk);
    hostRd(B + 12'd1, v); chk("R7 bad opcode status kept", v, 8'h80);
    chk("R7 no frames", expQ.size(), 0);

    // R5 clear after a failure, then a good write
    curReq = "R5";
    expWrite(8'h60, 8'h44, 8'h99);
    hostWr(B + 12'd4, 8'h44); hostWr(B + 12'd5, 8'h99);
    hostWr(B, 8'h05);
    hostRd(B + 12'd1, v); chk("R5 cleared after fail", v, 8'h00);
    waitDone(v); chk("R3 write status 2", v, 8'h04);
    repeat (50) @(negedge clk);
    chk("R9 idle sda released", sdaDriveLow, 0);
    chk("R3 scoreboard drained", expQ.size(), 0);

    summary();
  end
endmodule